// File: doc/BRIEF.md
# Predicated Bundle Commit Unit

This block decides, slot by slot, which results of a wide instruction bundle become architectural. A bundle is 128 bits and carries three 41-bit instructions above a 5-bit template. Every slot executes unconditionally elsewhere; this unit only decides whether each slot's result is written back. It does that by reading a one-bit predicate register named by the slot and raising that slot's write enable only when the predicate holds. Code on both arms of a branch can therefore be issued together, with only the arm whose predicate is true reaching the register file.

The unit owns 64 one-bit predicate registers. An equality-compare instruction writes two of them at once: the first named register receives the equality result and the second its complement. Register 0 is hard-wired true, so unpredicated code always commits. Two bundles (six slots) may be presented per cycle. Predicate updates take effect at the clock edge, so a compare becomes visible to other slots only from the next cycle. Write enables, destination numbers and result data are registered and appear one cycle after the bundle is presented.

Top module: `pred_bundle_commit`

## Requirements
- R1: Slot k (k = 0..2) of bundle b occupies bundle bits [b*128 + 5 + 41k + 40 : b*128 + 5 + 41k]; bits [4:0] of each bundle are a template that has no effect. Within a slot, bits [40:27] are the operation, [26:20] the first register field, [19:13] the second, [12:6] the third, [5:0] the qualifying predicate. The global slot index is g = 3b + k.
- R2: While reset is high and on the cycle after it falls, all write enables are 0 and the predicate state is 64'h1 (only register 0 set).
- R3: Predicate register 0 always reads 1; a compare naming it as either target leaves it at 1.
- R4: A valid slot whose operation is neither 0 nor 1 and whose qualifying predicate is 1 raises commit_we[g] on the next cycle, with commit_reg equal to its first register field and commit_data equal to its execution result.
- R5: A valid slot whose qualifying predicate is 0 raises no write enable.
- R6: Operation 0 is a no-op: it raises no write enable and changes no predicate, whatever its qualifying predicate.
- R7: Operation 1 is an equality compare: when valid and qualified true, on the next cycle the predicate named by the low 6 bits of its first register field equals (lhs == rhs) and the one named by the low 6 bits of its second register field equals the complement; the compare slot itself raises no write enable.
- R8: A compare whose qualifying predicate is 0 changes no predicate.
- R9: Slots presented in the same cycle as a compare read the predicate values from before that compare; the new values are used from the following cycle.
- R10: When several predicate writes in one cycle name the same register, the write from the higher global slot index wins; within one compare naming the same register twice, the complement wins.
- R11: A bundle whose valid bit is 0 raises no write enable and changes no predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bundle_vld | input | NUM_BUNDLES | Per-bundle valid |
| bundle_flat | input | NUM_BUNDLES*128 | Bundles, bundle b at bits [b*128 +: 128] |
| slot_result | input | 6*DATA_W | Execution result per global slot g at [g*DATA_W +: DATA_W] |
| cmp_lhs | input | 6*DATA_W | Compare left operand per global slot |
| cmp_rhs | input | 6*DATA_W | Compare right operand per global slot |
| commit_we | output | 6 | Registered write enable per global slot |
| commit_reg | output | 6*7 | Registered destination register number per slot |
| commit_data | output | 6*DATA_W | Registered result data per slot |
| pred_state | output | 64 | Current predicate registers, bit i is register i |

## Verification
The bench aims at a compare and a consumer of its predicate in the same cycle: a design that forwards the new value would commit the consumer one cycle early. It drives colliding predicate writes across both bundles and a compare naming one register twice; lowest-slot-wins or true-wins priority would leave the wrong bit. It targets register 0 with compares, where a design that stores the write would stop unpredicated code, and it presents no-ops and invalid bundles under true predicates, where a leaky gate would produce spurious writes. A long mixed stretch with few predicate numbers keeps these collisions frequent.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int SLOTS_PER_BUNDLE = 3;
    localparam int SLOT_W           = 41;
    localparam int TMPL_W           = 5;
    localparam int BUNDLE_W         = TMPL_W + SLOTS_PER_BUNDLE * SLOT_W;
    localparam int OP_W             = 14;
    localparam int REG_W            = 7;
    localparam int PRED_W           = 6;
    localparam int PRED_CNT         = 1 << PRED_W;

    localparam logic [OP_W-1:0] OP_NOP   = 14'd0;
    localparam logic [OP_W-1:0] OP_CMPEQ = 14'd1;

    // Field order from MSB to LSB of one slot.
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  ra;
        logic [REG_W-1:0]  rb;
        logic [REG_W-1:0]  rc;
        logic [PRED_W-1:0] qp;
    } slot_fields_t;

    typedef enum logic [1:0] {
        KIND_NOP = 2'd0,
        KIND_CMP = 2'd1,
        KIND_ALU = 2'd2
    } slot_kind_t;

    typedef struct packed {
        logic              wr_req;
        logic [REG_W-1:0]  dest;
        logic              cmp_we;
        logic [PRED_W-1:0] p_hit;
        logic [PRED_W-1:0] p_miss;
        logic              eq;
    } slot_dec_t;

    function automatic slot_kind_t classify(input logic [OP_W-1:0] op);
        if (op == OP_NOP)   return KIND_NOP;
        if (op == OP_CMPEQ) return KIND_CMP;
        return KIND_ALU;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [BUNDLE_W-1:0] bundle,
                                                  input int idx);
        return bundle[TMPL_W + idx * SLOT_W +: SLOT_W];
    endfunction

endpackage

// File: rtl/pbc_slot_decode.sv
module pbc_slot_decode
    import pbc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                valid,
    input  logic [SLOT_W-1:0]   slot_bits,
    input  logic [PRED_CNT-1:0] pred_state,
    input  logic [DATA_W-1:0]   cmp_a,
    input  logic [DATA_W-1:0]   cmp_b,
    output slot_dec_t           dec
);

    slot_fields_t fld;
    slot_kind_t   kind;
    logic         qual;

    always_comb begin
        fld  = slot_fields_t'(slot_bits);
        kind = classify(fld.op);
        qual = pred_state[fld.qp];

        dec.wr_req = valid && (kind == KIND_ALU) && qual;
        dec.dest   = fld.ra;
        dec.cmp_we = valid && (kind == KIND_CMP) && qual;
        dec.p_hit  = fld.ra[PRED_W-1:0];
        dec.p_miss = fld.rb[PRED_W-1:0];
        dec.eq     = (cmp_a == cmp_b);
    end

endmodule

// File: rtl/pbc_pred_file.sv
module pbc_pred_file
    import pbc_pkg::*;
#(
    parameter int NSLOT = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_dec_t           dec [NSLOT],
    output logic [PRED_CNT-1:0] pred_q
);

    localparam logic [PRED_CNT-1:0] RESET_VAL = {{(PRED_CNT-1){1'b0}}, 1'b1};

    logic [PRED_CNT-1:0] pred_nxt;

    // Slots are merged in ascending order so a higher slot overrides.
    always_comb begin
        pred_nxt = pred_q;
        for (int g = 0; g < NSLOT; g++) begin
            if (dec[g].cmp_we) begin
                pred_nxt[dec[g].p_hit]  = dec[g].eq;
                pred_nxt[dec[g].p_miss] = ~dec[g].eq;
            end
        end
        pred_nxt[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pred_q <= RESET_VAL;
        else     pred_q <= pred_nxt;
    end

endmodule

// File: rtl/pbc_commit_stage.sv
module pbc_commit_stage
    import pbc_pkg::*;
#(
    parameter int NSLOT  = 6,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  slot_dec_t                dec [NSLOT],
    input  logic [NSLOT*DATA_W-1:0]  result_flat,
    output logic [NSLOT-1:0]         we_q,
    output logic [NSLOT*REG_W-1:0]   reg_q,
    output logic [NSLOT*DATA_W-1:0]  data_q
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                we_q[g]                  <= 1'b0;
                reg_q[g*REG_W +: REG_W]  <= '0;
                data_q[g*DATA_W +: DATA_W] <= '0;
            end else begin
                we_q[g]                  <= dec[g].wr_req;
                reg_q[g*REG_W +: REG_W]  <= dec[g].dest;
                data_q[g*DATA_W +: DATA_W] <= result_flat[g*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/pred_bundle_commit.sv
module pred_bundle_commit
    import pbc_pkg::*;
#(
    parameter int NUM_BUNDLES = 2,
    parameter int DATA_W      = 32
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [NUM_BUNDLES-1:0]                       bundle_vld,
    input  logic [NUM_BUNDLES*BUNDLE_W-1:0]              bundle_flat,
    input  logic [NUM_BUNDLES*SLOTS_PER_BUNDLE*DATA_W-1:0] slot_result,
    input  logic [NUM_BUNDLES*SLOTS_PER_BUNDLE*DATA_W-1:0] cmp_lhs,
    input  logic [NUM_BUNDLES*SLOTS_PER_BUNDLE*DATA_W-1:0] cmp_rhs,
    output logic [NUM_BUNDLES*SLOTS_PER_BUNDLE-1:0]      commit_we,
    output logic [NUM_BUNDLES*SLOTS_PER_BUNDLE*REG_W-1:0] commit_reg,
    output logic [NUM_BUNDLES*SLOTS_PER_BUNDLE*DATA_W-1:0] commit_data,
    output logic [PRED_CNT-1:0]                          pred_state
);

    localparam int NSLOT = NUM_BUNDLES * SLOTS_PER_BUNDLE;

    slot_dec_t dec [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam int BI = g / SLOTS_PER_BUNDLE;
        localparam int SI = g % SLOTS_PER_BUNDLE;

        pbc_slot_decode #(.DATA_W(DATA_W)) u_dec (
            .valid      (bundle_vld[BI]),
            .slot_bits  (slot_of(bundle_flat[BI*BUNDLE_W +: BUNDLE_W], SI)),
            .pred_state (pred_state),
            .cmp_a      (cmp_lhs[g*DATA_W +: DATA_W]),
            .cmp_b      (cmp_rhs[g*DATA_W +: DATA_W]),
            .dec        (dec[g])
        );
    end

    pbc_pred_file #(.NSLOT(NSLOT)) u_pred (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .pred_q (pred_state)
    );

    pbc_commit_stage #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .result_flat (slot_result),
        .we_q        (commit_we),
        .reg_q       (commit_reg),
        .data_q      (commit_data)
    );

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker
    import pbc_pkg::*;
#(
    parameter int NUM_BUNDLES = 2
) (
    input logic                                    clk,
    input logic                                    rst,
    input logic [NUM_BUNDLES-1:0]                  bundle_vld,
    input logic [NUM_BUNDLES*BUNDLE_W-1:0]         bundle_flat,
    input logic [NUM_BUNDLES*SLOTS_PER_BUNDLE-1:0] commit_we,
    input logic [PRED_CNT-1:0]                     pred_state
);

    localparam int NSLOT = NUM_BUNDLES * SLOTS_PER_BUNDLE;

    logic             past_ok;
    logic [NSLOT-1:0] vld_s;
    logic [NSLOT-1:0] nop_s;
    logic [NSLOT-1:0] cmp_fire;
    logic [NSLOT-1:0] qual_s;
    slot_fields_t     fld [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    always_comb begin
        for (int g = 0; g < NSLOT; g++) begin
            fld[g]      = slot_fields_t'(slot_of(
                              bundle_flat[(g / SLOTS_PER_BUNDLE)*BUNDLE_W +: BUNDLE_W],
                              g % SLOTS_PER_BUNDLE));
            vld_s[g]    = bundle_vld[g / SLOTS_PER_BUNDLE];
            qual_s[g]   = pred_state[fld[g].qp];
            nop_s[g]    = vld_s[g] && (fld[g].op == OP_NOP);
            cmp_fire[g] = vld_s[g] && (fld[g].op == OP_CMPEQ) && qual_s[g];
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (commit_we == '0) && (pred_state == {{(PRED_CNT-1){1'b0}}, 1'b1})); // R2

    AST_P0_TRUE: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> pred_state[0]); // R3

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(nop_s[g])) |-> !commit_we[g]); // R6

        AST_FALSE_PRED_GATED: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(vld_s[g] && !qual_s[g])) |-> !commit_we[g]); // R5

        AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(!vld_s[g])) |-> !commit_we[g]); // R11

        AST_CMP_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(cmp_fire[g] && ($countones(cmp_fire) == 1)
                && (fld[g].ra[PRED_W-1:0] != fld[g].rb[PRED_W-1:0])
                && (fld[g].ra[PRED_W-1:0] != '0) && (fld[g].rb[PRED_W-1:0] != '0)))
            |-> (pred_state[$past(fld[g].ra[PRED_W-1:0])]
                 != pred_state[$past(fld[g].rb[PRED_W-1:0])])); // R7
    end

endmodule

bind pred_bundle_commit pbc_checker #(.NUM_BUNDLES(NUM_BUNDLES)) u_pbc_chk (
    .clk         (clk),
    .rst         (rst),
    .bundle_vld  (bundle_vld),
    .bundle_flat (bundle_flat),
    .commit_we   (commit_we),
    .pred_state  (pred_state)
);

// File: tb/test_pred_bundle_commit.sv
`timescale 1ns/1ps
module test_pred_bundle_commit;

    localparam int NB = 2;
    localparam int NS = 6;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [NB-1:0]     vld;
    logic [NB*128-1:0] bun;
    logic [NS*DW-1:0]  res, ca, cb;
    logic [NS-1:0]     c_we;
    logic [NS*7-1:0]   c_reg;
    logic [NS*DW-1:0]  c_data;
    logic [63:0]       pst;

    always #2.5 clk = ~clk;

    pred_bundle_commit #(.NUM_BUNDLES(NB), .DATA_W(DW)) i_pred_bundle_commit (
        .clk(clk), .rst(rst), .bundle_vld(vld), .bundle_flat(bun),
        .slot_result(res), .cmp_lhs(ca), .cmp_rhs(cb),
        .commit_we(c_we), .commit_reg(c_reg), .commit_data(c_data),
        .pred_state(pst)
    );

    typedef struct {
        logic [NS-1:0]    we;
        logic [NS*7-1:0]  rg;
        logic [NS*DW-1:0] dat;
        logic [63:0]      pred;
        string            tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] mdl;
    int          checks = 0;
    int          errors = 0;

    function automatic logic [40:0] mk(input logic [13:0] op, input logic [6:0] ra,
                                       input logic [6:0] rb, input logic [5:0] qp);
        return {op, ra, rb, 7'h55, qp};
    endfunction

    task automatic put(input int g, input logic [40:0] ins);
        bun[(g/3)*128 + 5 + (g%3)*41 +: 41] = ins;
    endtask

    task automatic clear_in();
        vld = '0;
        bun = '0;
        for (int b = 0; b < NB; b++) bun[b*128 +: 5] = 5'h1F; // template noise, R1
        for (int g = 0; g < NS; g++) begin
            res[g*DW +: DW] = $urandom;
            ca[g*DW +: DW]  = 32'h0;
            cb[g*DW +: DW]  = 32'h0;
        end
    endtask

    task automatic cmp_ops(input int g, input bit equal);
        ca[g*DW +: DW] = 32'h1234_0000 + g;
        cb[g*DW +: DW] = equal ? 32'h1234_0000 + g : 32'h9999_0000;
    endtask

    // Driver: computes the expected outcome, lets one edge pass, queues it.
    task automatic step(input string tag);
        exp_t        e;
        logic [63:0] nm;
        nm = mdl;
        e.we = '0; e.rg = '0; e.dat = '0;
        for (int g = 0; g < NS; g++) begin
            logic [40:0] ins;
            logic [13:0] op;
            logic        v;
            ins = bun[(g/3)*128 + 5 + (g%3)*41 +: 41];
            op  = ins[40:27];
            v   = vld[g/3];
            e.we[g]           = v && op != 14'd0 && op != 14'd1 && mdl[ins[5:0]];
            e.rg[g*7 +: 7]    = ins[26:20];
            e.dat[g*DW +: DW] = res[g*DW +: DW];
            if (v && op == 14'd1 && mdl[ins[5:0]]) begin
                nm[ins[25:20]] = (ca[g*DW +: DW] == cb[g*DW +: DW]);
                nm[ins[18:13]] = (ca[g*DW +: DW] != cb[g*DW +: DW]);
            end
        end
        nm[0]  = 1'b1;
        mdl    = nm;
        e.pred = nm;
        e.tag  = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: pops each expected item one cycle after its bundle.
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (c_we !== e.we) begin
                errors++;
                $display("FAIL %s commit_we actual=%b expected=%b", e.tag, c_we, e.we);
            end
            for (int g = 0; g < NS; g++) begin
                if (e.we[g]) begin
                    checks++;
                    if (c_reg[g*7 +: 7] !== e.rg[g*7 +: 7] ||
                        c_data[g*DW +: DW] !== e.dat[g*DW +: DW]) begin
                        errors++;
                        $display("FAIL %s slot %0d reg/data actual=%h/%h expected=%h/%h",
                                 e.tag, g, c_reg[g*7 +: 7], c_data[g*DW +: DW],
                                 e.rg[g*7 +: 7], e.dat[g*DW +: DW]);
                    end
                end
            end
            checks++;
            if (pst !== e.pred) begin
                errors++;
                $display("FAIL %s pred_state actual=%h expected=%h", e.tag, pst, e.pred);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clear_in();
        mdl = 64'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (c_we !== '0 || pst !== 64'h1) begin
            errors++;
            $display("FAIL R2 in reset actual=%b/%h expected=0/1", c_we, pst);
        end
        rst = 1'b0;

        clear_in(); step("R2");

        // R4 / R1: ALU ops in every slot with the always-true predicate
        clear_in(); vld = 2'b11;
        for (int g = 0; g < NS; g++) put(g, mk(14'd100 + 14'(g), 7'(10 + g), 7'd3, 6'd0));
        step("R4_R1");

        // R5: false predicate; R6: no-ops under true predicate
        clear_in(); vld = 2'b11;
        put(0, mk(14'd7, 7'd20, 7'd0, 6'd5));
        put(4, mk(14'd7, 7'd21, 7'd0, 6'd33));
        put(1, mk(14'd0, 7'd22, 7'd0, 6'd0));
        put(5, mk(14'd0, 7'd23, 7'd0, 6'd0));
        step("R5_R6");

        // R7 + R9: compare sets p5=1/p6=0; same-cycle reader of p5 sees old 0
        clear_in(); vld = 2'b11;
        put(0, mk(14'd1, 7'd5, 7'd6, 6'd0)); cmp_ops(0, 1'b1);
        put(1, mk(14'd9, 7'd30, 7'd0, 6'd5));
        put(3, mk(14'd9, 7'd31, 7'd0, 6'd0));
        step("R7_R9");

        // R9: next cycle readers see p5=1 and p6=0
        clear_in(); vld = 2'b01;
        put(0, mk(14'd9, 7'd40, 7'd0, 6'd5));
        put(2, mk(14'd9, 7'd41, 7'd0, 6'd6));
        step("R9");

        // R7: unequal operands flip the pair
        clear_in(); vld = 2'b10;
        put(4, mk(14'd1, 7'd5, 7'd6, 6'd0)); cmp_ops(4, 1'b0);
        step("R7");

        // R3: compare aimed at register 0 from both sides
        clear_in(); vld = 2'b11;
        put(0, mk(14'd1, 7'd0, 7'd12, 6'd0)); cmp_ops(0, 1'b0);
        put(3, mk(14'd1, 7'd13, 7'd0, 6'd0)); cmp_ops(3, 1'b1);
        step("R3");
        clear_in(); vld = 2'b01;
        put(0, mk(14'd9, 7'd44, 7'd0, 6'd0));
        step("R3");

        // R8: compare qualified by false p5 leaves its targets alone
        clear_in(); vld = 2'b01;
        put(1, mk(14'd1, 7'd6, 7'd12, 6'd5)); cmp_ops(1, 1'b1);
        step("R8");

        // R10: slot 0 sets p7=1, slot 5 sets p7=0 -> higher slot wins
        clear_in(); vld = 2'b11;
        put(0, mk(14'd1, 7'd7, 7'd8, 6'd0)); cmp_ops(0, 1'b1);
        put(5, mk(14'd1, 7'd8, 7'd7, 6'd0)); cmp_ops(5, 1'b1);
        step("R10");

        // R10: set p9=1, then a compare naming p9 twice -> complement wins
        clear_in(); vld = 2'b01;
        put(2, mk(14'd1, 7'd9, 7'd10, 6'd0)); cmp_ops(2, 1'b1);
        step("R10");
        clear_in(); vld = 2'b10;
        put(3, mk(14'd1, 7'd9, 7'd9, 6'd0)); cmp_ops(3, 1'b1);
        step("R10");

        // R11: invalid bundles with live ops and compares do nothing
        clear_in(); vld = 2'b00;
        for (int g = 0; g < NS; g++) put(g, mk(14'd1 + 14'(g % 2), 7'd9, 7'd10, 6'd0));
        for (int g = 0; g < NS; g++) cmp_ops(g, 1'b0);
        step("R11");

        // Mixed stretch with few predicate numbers (R4 R5 R7 R10 R11)
        for (int n = 0; n < 400; n++) begin
            clear_in();
            vld = 2'($urandom);
            for (int g = 0; g < NS; g++) begin
                logic [13:0] op;
                case ($urandom % 4)
                    0: op = 14'd0;
                    1: op = 14'd1;
                    default: op = 14'(2 + $urandom % 1000);
                endcase
                put(g, mk(op, 7'($urandom % 8), 7'($urandom % 8), 6'($urandom % 8)));
                cmp_ops(g, 1'($urandom));
            end
            step("R4_R7_R10_mix");
        end

        clear_in();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule